// File: doc/BRIEF.md
# Timer Compare Match Output

This block is a free-running 16-bit up-counter that advances one step on each cycle where a tick enable is high. A compare register sits beside it. When a tick moves the count onto the compare value, the block acts on an output pin and raises a sticky interrupt flag. A two-bit mode input selects what happens to the pin on a match: it toggles, goes high, goes low, or is left alone so that only the flag is raised.

Software can preload the timer through a write port, so the first match happens after a chosen number of ticks. It can also rewrite the compare register at any time. If the restart option is on, the count returns to zero on the tick after a match. The matches then repeat every compare-value-plus-one ticks. In toggle mode this gives a periodic square wave with no processor involvement. Prescaling of the tick is done outside the block.

Top module: `cmp_match_timer`

## Requirements
- R1: After reset the count is 0, the pin is low, the flag is clear and the compare register holds 0xFFFF.
- R2: A cycle with tick high and no preload raises the count by one. Without restart the count wraps from 0xFFFF to 0. A cycle with tick low and no preload leaves the count unchanged.
- R3: A preload write sets the count to the written value on the next cycle. It takes priority over a tick in the same cycle, and a preload never causes a match, even when the loaded value equals the compare value.
- R4: A match event happens only when a tick moves the count to a value equal to the compare register. A count that stays equal without ticks produces no event, and neither does writing a compare value equal to the current count.
- R5: On a match the pin is updated at the same clock edge at which the count takes the matched value. The action depends on the mode: 2'b00 toggles the pin, 2'b01 drives it high, 2'b10 drives it low and 2'b11 leaves it unchanged. The pin changes at no other time.
- R6: A match sets the flag. The flag then stays set until the clear input is applied in a cycle with no match. If a match and a clear fall in the same cycle, the flag is set.
- R7: With restart enabled, a tick while the count equals the compare value takes the count to 0. Matches then repeat every compare-value-plus-one ticks, and a compare value of 0 gives a match on every tick.
- R8: A compare write takes effect on the next cycle. A match in the cycle of the write is judged against the previous compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for one step |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | New compare value |
| load_we | input | 1 | Timer preload strobe |
| load_wdata | input | 16 | Preload value |
| mode | input | 2 | Pin action on a match |
| restart_en | input | 1 | Return the count to zero after a match |
| irq_clr | input | 1 | Clear the interrupt flag |
| pin_out | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky match flag |
| count_out | output | 16 | Current timer count |

## Verification
The assertions assume that every input is a synchronous level that is stable around the rising edge. They also assume that a compare write in a match cycle is the only way the compare value and a freshly raised flag can disagree, and they exclude that case explicitly. The random stimulus drives all inputs only between edges. It draws compare and preload values close to the current count so that matches, restarts and the same-cycle clear, write and preload collisions happen often. Directed sequences cover the wrap at 0xFFFF, a compare value of 0 with restart, and an equal count with no tick.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ACT_TOGGLE = 2'b00,
        ACT_HIGH   = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_NONE   = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic pin;
    } pin_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/cmt_cmp_reg.sv
module cmt_cmp_reg #(
    parameter int          W         = 16,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cmp_q
);

    typedef struct packed {
        logic [W-1:0] value;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_q = st_q.value;

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         restart_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt_q,
    output logic         hit
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (restart_en && (st_q.cnt == cmp_val)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
            hit_d = (st_d.cnt == cmp_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign hit   = hit_d;

endmodule

// File: rtl/cmt_pin_unit.sv
module cmt_pin_unit
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] mode,
    output logic       pin
);

    pin_state_t st_d, st_q;
    pin_act_e   act;

    assign act = pin_act_e'(mode);

    always_comb begin
        st_d = st_q;
        if (hit) begin
            unique case (act)
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                ACT_HIGH:   st_d.pin = 1'b1;
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_NONE:   st_d.pin = st_q.pin;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pin <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin = st_q.pin;

endmodule

// File: rtl/cmt_flag_unit.sv
module cmt_flag_unit
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         load_we,
    input  logic [W-1:0] load_wdata,
    input  logic [1:0]   mode,
    input  logic         restart_en,
    input  logic         irq_clr,
    output logic         pin_out,
    output logic         irq_flag,
    output logic [W-1:0] count_out
);

    localparam logic [W-1:0] CMP_RESET = '1;

    logic [W-1:0] cmp_val;
    logic         hit;

    cmt_cmp_reg #(.W(W), .RESET_VAL(CMP_RESET)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_we),
        .wr_val (cmp_wdata),
        .cmp_q  (cmp_val)
    );

    cmt_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (load_we),
        .load_val   (load_wdata),
        .restart_en (restart_en),
        .cmp_val    (cmp_val),
        .cnt_q      (count_out),
        .hit        (hit)
    );

    cmt_pin_unit u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .mode  (mode),
        .pin   (pin_out)
    );

    cmt_flag_unit u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (irq_clr),
        .flag  (irq_flag)
    );

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         cmp_we,
    input logic         load_we,
    input logic [W-1:0] load_wdata,
    input logic [1:0]   mode,
    input logic         restart_en,
    input logic         irq_clr,
    input logic         pin_out,
    input logic         irq_flag,
    input logic [W-1:0] count_out,
    input logic [W-1:0] cmp_val
);

    // R3
    preload_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count_out == $past(load_wdata));

    // R5
    pin_quiet_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_out));

    // R5
    pin_quiet_none_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> $stable(pin_out));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R4
    flag_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_flag) && !$past(cmp_we)) |-> count_out == cmp_val);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !tick) |=> !irq_flag);

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && restart_en && count_out == cmp_val) |=> count_out == '0);

endmodule

bind cmp_match_timer cmt_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmp_we     (cmp_we),
    .load_we    (load_we),
    .load_wdata (load_wdata),
    .mode       (mode),
    .restart_en (restart_en),
    .irq_clr    (irq_clr),
    .pin_out    (pin_out),
    .irq_flag   (irq_flag),
    .count_out  (count_out),
    .cmp_val    (cmp_val)
);

// File: tb/sim_cmp_match_timer.sv
`timescale 1ns/1ps
module sim_cmp_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cmp_we = 1'b0, load_we = 1'b0;
    logic [15:0] cmp_wdata = '0, load_wdata = '0;
    logic [1:0]  mode = 2'b00;
    logic        restart_en = 1'b0, irq_clr = 1'b0;
    logic        pin_out, irq_flag;
    logic [15:0] count_out;

    int n_run = 0, n_fail = 0;
    logic [15:0] m_cnt, m_cmp;
    logic        m_pin, m_flag;

    always #2.5 clk = ~clk;

    cmp_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .load_we(load_we), .load_wdata(load_wdata), .mode(mode), .restart_en(restart_en),
        .irq_clr(irq_clr), .pin_out(pin_out), .irq_flag(irq_flag), .count_out(count_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next-count rule from R2/R3/R7, match rule from R4, actions from R5/R6, compare from R8
    function automatic logic [15:0] next_count(input logic [15:0] c, input logic [15:0] k);
        if (load_we) return load_wdata;
        if (!tick) return c;
        if (restart_en && c == k) return 16'h0000;
        return c + 16'h0001;
    endfunction

    function automatic logic next_pin(input logic p, input logic hit, input logic [1:0] md);
        if (!hit) return p;
        case (md)
            2'b00: return ~p;
            2'b01: return 1'b1;
            2'b10: return 1'b0;
            default: return p;
        endcase
    endfunction

    task automatic cyc();
        logic [15:0] nc;
        logic        hit;
        @(posedge clk);
        nc     = next_count(m_cnt, m_cmp);
        hit    = tick && !load_we && (nc == m_cmp);
        m_pin  = next_pin(m_pin, hit, mode);
        m_flag = hit ? 1'b1 : (irq_clr ? 1'b0 : m_flag);
        m_cmp  = cmp_we ? cmp_wdata : m_cmp;
        m_cnt  = nc;
        #1;
        check("R2 count", 32'(count_out), 32'(m_cnt));
        check("R5 pin", 32'(pin_out), 32'(m_pin));
        check("R6 flag", 32'(irq_flag), 32'(m_flag));
    endtask

    task automatic idle();
        tick = 0; cmp_we = 0; load_we = 0; irq_clr = 0;
    endtask

    task automatic do_load(input logic [15:0] v);
        idle(); load_we = 1; load_wdata = v; cyc(); idle();
    endtask

    task automatic do_cmp(input logic [15:0] v);
        idle(); cmp_we = 1; cmp_wdata = v; cyc(); idle();
    endtask

    task automatic do_clr();
        idle(); irq_clr = 1; cyc(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int toggles;
        logic prev;
        void'($urandom(32'd1234));
        m_cnt = 0; m_cmp = 16'hFFFF; m_pin = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 count", 32'(count_out), 0);
        check("R1 pin", 32'(pin_out), 0);
        check("R1 flag", 32'(irq_flag), 0);
        rst_n = 1;
        cyc();
        // R1 compare reset value: reaching 0xFFFF matches
        do_load(16'hFFFE);
        tick = 1; cyc(); idle();
        check("R1 cmp reset value", 32'(irq_flag), 1);
        // R2 wrap without restart
        do_clr(); do_cmp(16'h0005);
        tick = 1; cyc(); idle();
        check("R2 wrap to zero", 32'(count_out), 0);
        cyc();
        check("R2 hold without tick", 32'(count_out), 0);
        // R3 preload equal to compare: no match
        do_cmp(16'd20); prev = pin_out;
        do_load(16'd20);
        check("R3 preload no flag", 32'(irq_flag), 0);
        check("R3 preload no pin", 32'(pin_out), 32'(prev));
        idle(); load_we = 1; load_wdata = 16'd7; tick = 1; cyc(); idle();
        check("R3 preload beats tick", 32'(count_out), 7);
        // R4 compare equal to count without tick
        do_cmp(16'd7); cyc(); cyc();
        check("R4 no event when idle equal", 32'(irq_flag), 0);
        // R5 modes
        do_load(16'd6); mode = 2'b01; tick = 1; cyc(); idle();
        check("R5 high", 32'(pin_out), 1);
        do_load(16'd6); mode = 2'b10; tick = 1; cyc(); idle();
        check("R5 low", 32'(pin_out), 0);
        do_load(16'd6); mode = 2'b11; tick = 1; cyc(); idle();
        check("R5 none", 32'(pin_out), 0);
        do_load(16'd6); mode = 2'b00; tick = 1; cyc(); idle();
        check("R5 toggle", 32'(pin_out), 1);
        // R6 set wins over clear
        do_clr(); do_load(16'd6); tick = 1; irq_clr = 1; cyc(); idle();
        check("R6 set beats clear", 32'(irq_flag), 1);
        do_clr();
        check("R6 cleared", 32'(irq_flag), 0);
        // R8 compare write in match cycle uses old value
        do_load(16'd6); tick = 1; cmp_we = 1; cmp_wdata = 16'd100; cyc(); idle();
        check("R8 old compare used", 32'(irq_flag), 1);
        do_clr(); do_load(16'd99); tick = 1; cyc(); idle();
        check("R8 new compare active", 32'(irq_flag), 1);
        // R7 periodic restart, compare 4: 15 ticks -> 3 toggles
        do_clr(); do_cmp(16'd4); do_load(16'd0); restart_en = 1; mode = 2'b00;
        toggles = 0;
        for (int i = 0; i < 15; i++) begin
            prev = pin_out; tick = 1; cyc();
            if (pin_out != prev) toggles++;
        end
        idle();
        check("R7 period compare+1", 32'(toggles), 3);
        do_cmp(16'd0); do_load(16'd0); toggles = 0;
        for (int i = 0; i < 5; i++) begin
            prev = pin_out; tick = 1; cyc();
            if (pin_out != prev) toggles++;
        end
        idle();
        check("R7 compare zero every tick", 32'(toggles), 5);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            tick       = (r[3:0] < 4'd11);
            load_we    = (r[7:4] == 4'd0);
            load_wdata = m_cnt + 16'($urandom_range(0, 6)) - 16'd2;
            cmp_we     = (r[11:8] == 4'd0);
            cmp_wdata  = m_cnt + 16'($urandom_range(0, 8));
            irq_clr    = (r[14:12] == 3'd0);
            mode       = r[17:16];
            if (r[22:20] == 3'd0) restart_en = ~restart_en;
            cyc();
        end
        idle();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule